// File: doc/BRIEF.md
# Reference Clock Loss Monitor and Priority Selector

This block supervises up to four reference clocks from a fast free-running monitor clock and names the reference that a downstream clock-recovery loop should follow. Each reference goes through its own synchronizer. A restartable timeout counter then measures how long that reference has gone without an edge. When a reference stays silent for its programmed number of monitor cycles, it is marked lost. The selection then moves to the best remaining qualified reference in priority order. When no qualified reference is left, the block raises a holdover flag.

A lost reference does not come back at once. It is qualified again only after a run of consecutive good periods, and the length of that run is programmable. Every new loss sets a sticky alarm bit. Software clears these bits by writing ones. The interrupt line is the OR of the alarm bits that are enabled. Limits and priorities are per-input registers written through a small write port. A write-protect pin blocks those writes, but it never blocks the clearing of alarms. All pins are plain control and status signals, and no port has back-pressure.

Top module: `refclk_los_selector`

## Requirements
- R1: Each reference passes through a toggle-and-two-flop synchronizer. A rising edge of a reference is seen by its monitor at the third monitor-clock rising edge after the reference edge.
- R2: Each monitor counter clears on every recognized edge. If no recognized edge arrives for `limit` monitor edges in a row, the input's bit in `los_status` goes to 1 on the limit-th of those edges. The limit is a per-input register with a reset value of 20.
- R3: After reset, every `los_status` bit is 1, `holdover` is 1, `sel_idx` is 0, and all alarm bits and `irq` are 0.
- R4: A lost input returns to 0 in `los_status` only after `need_good` consecutive recognized edges, where each edge arrives before the counter reaches the limit. A value of 0 counts as 1. A timeout in the middle of the run restarts the count.
- R5: `sel_idx` names the input that has the lowest non-zero priority code among the inputs whose loss bit was 0 one cycle earlier. Code 1 is the highest priority. When codes are equal, the lowest index wins. Selection is revertive.
- R6: `holdover` is 1 when no input qualifies, and `sel_idx` keeps its last value while `holdover` is 1.
- R7: An alarm bit is set on each 0-to-1 change of the matching loss bit. The alarm bit stays set until a 1 is applied on the matching `alarm_clr` bit. If a set and a clear occur in the same cycle, the set wins.
- R8: `irq` is 1 exactly when some alarm bit and its `irq_en` bit are both 1.
- R9: When `cfg_we` is 1, the limit and priority of input `cfg_sel` are written at the next edge. The write is ignored while `cfg_wp` is 1. `cfg_wp` has no effect on alarm clearing. The reset priority of input i is i+1.
- R10: An input whose priority code is 0 is never selected, even when it is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 4 | Reference clocks, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | Write protect for configuration registers |
| cfg_sel | input | 2 | Input index being written |
| cfg_limit | input | 16 | Timeout limit in monitor cycles |
| cfg_prio | input | 3 | Priority code, 0 disables |
| need_good | input | 4 | Good periods required to requalify |
| irq_en | input | 4 | Per-input interrupt enable |
| alarm_clr | input | 4 | Write-one-to-clear for the alarm bits |
| los_status | output | 4 | Per-input loss flag |
| alarm_sticky | output | 4 | Sticky loss alarms |
| irq | output | 1 | Interrupt request |
| sel_idx | output | 2 | Selected reference |
| holdover | output | 1 | No qualified reference |

## Verification
The bound checker checks the following on every cycle:
- an alarm bit never drops without a clear pulse;
- each loss rise sets the matching alarm bit;
- a raised `irq` always has an alarm behind it;
- a selected reference was qualified in the previous cycle;
- the selection never moves while in holdover.

Only the bench scenarios can show the rest. This covers the exact cycle at which a silent reference times out, the requalification run, the tie and disable rules of the priority order, and the fact that write protect blocks configuration writes but not alarm clears. The bench follows all of these through a behavioural model that runs cycle by cycle.

// File: rtl/refclk_los_pkg.sv
package refclk_los_pkg;
  localparam int unsigned DEF_N_REF  = 4;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_PRI_W  = 3;
  localparam int unsigned DEF_GOOD_W = 4;
  localparam int unsigned DEF_LIMIT  = 20;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/refclk_edge_sync.sv
module refclk_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic edge_p
);
  logic       tog;
  logic [2:0] sh;

  // toggle in the reference domain
  always_ff @(posedge ref_in or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  // two synchronizing flops plus one history flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], tog};
  end

  assign edge_p = sh[1] ^ sh[2];
endmodule

// File: rtl/refclk_los_monitor.sv
module refclk_los_monitor #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned GOOD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_p,
  input  logic [CNT_W-1:0]  limit,
  input  logic [GOOD_W-1:0] need,
  output logic              los,
  output logic              loss_rise
);
  logic [CNT_W-1:0]  cnt;
  logic [GOOD_W-1:0] good;
  logic [CNT_W:0]    cnt_inc;
  logic [GOOD_W:0]   good_inc;
  logic [GOOD_W-1:0] need_eff;
  logic              timeout;
  logic              in_window;

  assign cnt_inc   = {1'b0, cnt} + 1'b1;
  assign good_inc  = {1'b0, good} + 1'b1;
  assign need_eff  = (need == '0) ? GOOD_W'(1) : need;
  assign in_window = (cnt < limit);
  assign timeout   = !edge_p && (cnt_inc >= {1'b0, limit});
  assign loss_rise = timeout && !los;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      good <= '0;
      los  <= 1'b1;
    end else if (edge_p) begin
      cnt <= '0;
      if (los) begin
        if (!in_window) begin
          good <= '0;
        end else if (good_inc >= {1'b0, need_eff}) begin
          los  <= 1'b0;
          good <= '0;
        end else begin
          good <= good_inc[GOOD_W-1:0];
        end
      end
    end else begin
      if (in_window) cnt <= cnt_inc[CNT_W-1:0];
      if (timeout) begin
        los  <= 1'b1;
        good <= '0;
      end
    end
  end
endmodule

// File: rtl/refclk_prio_select.sv
module refclk_prio_select #(
  parameter int unsigned N_REF = 4,
  parameter int unsigned PRI_W = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REF-1:0]       los,
  input  logic [N_REF*PRI_W-1:0] prio,
  output logic [IDX_W-1:0]       sel_idx,
  output logic                   holdover
);
  logic             found;
  logic [PRI_W-1:0] best_p;
  logic [IDX_W-1:0] best_i;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < N_REF; i++) begin
      if (!los[i] && (prio[i*PRI_W +: PRI_W] != '0) &&
          (!found || (prio[i*PRI_W +: PRI_W] < best_p))) begin
        found  = 1'b1;
        best_p = prio[i*PRI_W +: PRI_W];
        best_i = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx  <= '0;
      holdover <= 1'b1;
    end else if (found) begin
      sel_idx  <= best_i;
      holdover <= 1'b0;
    end else begin
      holdover <= 1'b1;
    end
  end
endmodule

// File: rtl/refclk_alarm.sv
module refclk_alarm #(
  parameter int unsigned N_REF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REF-1:0] rise,
  input  logic [N_REF-1:0] clr,
  input  logic [N_REF-1:0] en,
  output logic [N_REF-1:0] sticky,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~clr) | rise;
  end

  assign irq = |(sticky & en);
endmodule

// File: rtl/refclk_los_selector.sv
module refclk_los_selector
  import refclk_los_pkg::*;
#(
  parameter int unsigned N_REF     = DEF_N_REF,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned PRI_W     = DEF_PRI_W,
  parameter int unsigned GOOD_W    = DEF_GOOD_W,
  parameter int unsigned RST_LIMIT = DEF_LIMIT,
  localparam int unsigned IDX_W    = idx_width(N_REF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REF-1:0]  ref_in,
  input  logic              cfg_we,
  input  logic              cfg_wp,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [CNT_W-1:0]  cfg_limit,
  input  logic [PRI_W-1:0]  cfg_prio,
  input  logic [GOOD_W-1:0] need_good,
  input  logic [N_REF-1:0]  irq_en,
  input  logic [N_REF-1:0]  alarm_clr,
  output logic [N_REF-1:0]  los_status,
  output logic [N_REF-1:0]  alarm_sticky,
  output logic              irq,
  output logic [IDX_W-1:0]  sel_idx,
  output logic              holdover
);
  logic [N_REF-1:0]       edge_p;
  logic [N_REF-1:0]       rise;
  logic [N_REF*CNT_W-1:0] limit_q;
  logic [N_REF*PRI_W-1:0] prio_q;

  for (genvar g = 0; g < N_REF; g++) begin : g_ref
    logic wr_hit;
    assign wr_hit = cfg_we && !cfg_wp && (cfg_sel == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        limit_q[g*CNT_W +: CNT_W] <= CNT_W'(RST_LIMIT);
        prio_q[g*PRI_W +: PRI_W]  <= PRI_W'(g + 1);
      end else if (wr_hit) begin
        limit_q[g*CNT_W +: CNT_W] <= cfg_limit;
        prio_q[g*PRI_W +: PRI_W]  <= cfg_prio;
      end
    end

    refclk_edge_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_in (ref_in[g]),
      .edge_p (edge_p[g])
    );

    refclk_los_monitor #(.CNT_W(CNT_W), .GOOD_W(GOOD_W)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_p    (edge_p[g]),
      .limit     (limit_q[g*CNT_W +: CNT_W]),
      .need      (need_good),
      .los       (los_status[g]),
      .loss_rise (rise[g])
    );
  end

  refclk_prio_select #(.N_REF(N_REF), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .los      (los_status),
    .prio     (prio_q),
    .sel_idx  (sel_idx),
    .holdover (holdover)
  );

  refclk_alarm #(.N_REF(N_REF)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise),
    .clr    (alarm_clr),
    .en     (irq_en),
    .sticky (alarm_sticky),
    .irq    (irq)
  );
endmodule

// File: rtl/refclk_los_checker.sv
module refclk_los_checker #(
  parameter int unsigned N_REF = 4,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REF-1:0] los_status,
  input logic [N_REF-1:0] alarm_sticky,
  input logic [N_REF-1:0] alarm_clr,
  input logic             irq,
  input logic [IDX_W-1:0] sel_idx,
  input logic             holdover
);
  logic [N_REF-1:0] los_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) los_prev <= '1;
    else        los_prev <= los_status;
  end

  for (genvar g = 0; g < N_REF; g++) begin : g_chk
    a_r7_sticky_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm_sticky[g]) |-> $past(alarm_clr[g]));
    a_r7_loss_sets_alarm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(los_status[g]) |-> alarm_sticky[g]);
  end

  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alarm_sticky != '0));

  a_r5_selected_was_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !holdover |-> !los_prev[sel_idx]);

  a_r6_hold_freezes_select: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_idx) |-> !holdover);
endmodule

bind refclk_los_selector refclk_los_checker #(.N_REF(N_REF), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .los_status   (los_status),
  .alarm_sticky (alarm_sticky),
  .alarm_clr    (alarm_clr),
  .irq          (irq),
  .sel_idx      (sel_idx),
  .holdover     (holdover)
);

// File: tb/sim_refclk_los_selector.sv
module sim_refclk_los_selector;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ref_in = '0;
  logic        cfg_we = 1'b0, cfg_wp = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_limit = '0;
  logic [2:0]  cfg_prio = '0;
  logic [3:0]  need_good = 4'd3;
  logic [3:0]  irq_en = 4'b0101;
  logic [3:0]  alarm_clr = '0;
  logic [3:0]  los_status, alarm_sticky;
  logic        irq, holdover;
  logic [1:0]  sel_idx;

  refclk_los_selector u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .cfg_we(cfg_we), .cfg_wp(cfg_wp),
    .cfg_sel(cfg_sel), .cfg_limit(cfg_limit), .cfg_prio(cfg_prio),
    .need_good(need_good), .irq_en(irq_en), .alarm_clr(alarm_clr),
    .los_status(los_status), .alarm_sticky(alarm_sticky), .irq(irq),
    .sel_idx(sel_idx), .holdover(holdover)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus: per-reference period in monitor cycles, 0 = stopped
  int per[N];
  int ph[N];
  bit rose0[N], rose1[N], rose2[N];

  task automatic drive_refs();
    for (int i = 0; i < N; i++) begin
      bit nv;
      if (per[i] > 0) begin
        ph[i] = (ph[i] + 1) % per[i];
        nv = (ph[i] < per[i] / 2);
      end else begin
        nv = 1'b0;
      end
      if (nv && !ref_in[i]) rose0[i] = 1'b1;
      ref_in[i] = nv;
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drive_refs();
    end
  endtask

  task automatic cfg_write(int idx, int lim, int pr);
    cfg_sel = 2'(idx); cfg_limit = 16'(lim); cfg_prio = 3'(pr); cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  // behavioural reference model
  int  m_cnt[N], m_good[N], m_lim[N], m_prio[N];
  bit  m_los[N], m_stk[N];
  int  m_sel;
  bit  m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_cnt[i] = 0; m_good[i] = 0; m_lim[i] = 20; m_prio[i] = i + 1;
        m_los[i] = 1; m_stk[i] = 0; rose1[i] = 0; rose2[i] = 0;
      end
      m_sel = 0; m_hold = 1;
    end else begin
      int bp, bi, needeff;
      bit e, tmo, rise;
      bp = 0; bi = -1;
      for (int i = 0; i < N; i++)
        if (!m_los[i] && m_prio[i] != 0 && (bi < 0 || m_prio[i] < bp)) begin
          bp = m_prio[i]; bi = i;
        end
      if (bi >= 0) begin m_sel = bi; m_hold = 0; end
      else m_hold = 1;
      needeff = (need_good == 0) ? 1 : int'(need_good);
      for (int i = 0; i < N; i++) begin
        e = rose2[i];
        rise = 0;
        tmo = !e && (m_cnt[i] + 1 >= m_lim[i]);
        if (e) begin
          if (m_los[i]) begin
            if (m_cnt[i] >= m_lim[i]) m_good[i] = 0;
            else if (m_good[i] + 1 >= needeff) begin m_los[i] = 0; m_good[i] = 0; end
            else m_good[i]++;
          end
          m_cnt[i] = 0;
        end else begin
          if (m_cnt[i] < m_lim[i]) m_cnt[i]++;
          if (tmo) begin rise = !m_los[i]; m_los[i] = 1; m_good[i] = 0; end
        end
        m_stk[i] = (m_stk[i] && !alarm_clr[i]) || rise;
      end
      if (cfg_we && !cfg_wp) begin
        m_lim[cfg_sel] = int'(cfg_limit);
        m_prio[cfg_sel] = int'(cfg_prio);
      end
      for (int i = 0; i < N; i++) begin
        rose2[i] = rose1[i]; rose1[i] = rose0[i]; rose0[i] = 0;
      end
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      int el, es, ei;
      el = 0; es = 0; ei = 0;
      for (int i = 0; i < N; i++) begin
        el |= int'(m_los[i]) << i;
        es |= int'(m_stk[i]) << i;
        if (m_stk[i] && irq_en[i]) ei = 1;
      end
      chk("R1/R2 los_status", int'(los_status), el);
      chk("R7 alarm_sticky", int'(alarm_sticky), es);
      chk("R8 irq", int'(irq), ei);
      chk("R6 holdover", int'(holdover), int'(m_hold));
      chk("R5 sel_idx", int'(sel_idx), m_sel);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin per[i] = 0; ph[i] = 0; rose0[i] = 0; end
    step(3);
    rst_n = 1'b1;
    step(1);
    // R3 reset state
    chk("R3 los after reset", int'(los_status), 15);
    chk("R3 holdover after reset", int'(holdover), 1);
    chk("R3 sel after reset", int'(sel_idx), 0);
    chk("R3 alarms after reset", int'(alarm_sticky), 0);
    chk("R3 irq after reset", int'(irq), 0);

    // R4 qualification of all inputs
    for (int i = 0; i < N; i++) begin per[i] = 8; ph[i] = per[i] - 1 - i; end
    step(12);
    chk("R4 not yet qualified", int'(los_status[0]), 1);
    step(40);
    chk("R4 all qualified", int'(los_status), 0);
    chk("R5 highest priority chosen", int'(sel_idx), 0);

    // R2 loss of input 0, R7/R8 alarm
    per[0] = 0;
    step(40);
    chk("R2 input0 lost", int'(los_status[0]), 1);
    chk("R5 moved to input1", int'(sel_idx), 1);
    chk("R7 alarm0 set", int'(alarm_sticky[0]), 1);
    chk("R8 irq raised", int'(irq), 1);
    alarm_clr = 4'b0001; step(1); alarm_clr = 4'b0000; step(1);
    chk("R7 alarm0 cleared", int'(alarm_sticky[0]), 0);
    chk("R8 irq dropped", int'(irq), 0);

    // R9 writes, R5 tie breaking
    cfg_write(3, 20, 1); step(2);
    chk("R9 prio write moves select", int'(sel_idx), 3);
    cfg_write(2, 20, 1); step(2);
    chk("R5 tie lowest index", int'(sel_idx), 2);

    // R9 write protect blocks writes but not alarm clear
    cfg_wp = 1'b1;
    cfg_write(2, 20, 0); step(2);
    chk("R9 protected write ignored", int'(sel_idx), 2);
    per[2] = 0; step(40);
    chk("R9 input2 lost", int'(alarm_sticky[2]), 1);
    chk("R5 fallback to input3", int'(sel_idx), 3);
    alarm_clr = 4'b0100; step(1); alarm_clr = 4'b0000; step(1);
    chk("R9 clear under protect", int'(alarm_sticky[2]), 0);
    cfg_wp = 1'b0;

    // R10 disabled priority
    cfg_write(3, 20, 0); step(2);
    chk("R10 disabled input skipped", int'(sel_idx), 1);

    // R2 limit boundary on input1 (period 8)
    cfg_write(1, 8, 2); step(30);
    chk("R2 limit 8 keeps input1", int'(los_status[1]), 0);
    cfg_write(1, 7, 2); step(30);
    chk("R2 limit 7 loses input1", int'(los_status[1]), 1);
    chk("R6 holdover with no candidate", int'(holdover), 1);
    chk("R6 select held", int'(sel_idx), 1);

    // R4 requalify input0 with a broken run
    need_good = 4'd4;
    per[0] = 8; ph[0] = 7;
    step(20);
    per[0] = 0; step(30);
    chk("R4 broken run stays lost", int'(los_status[0]), 1);
    per[0] = 8; ph[0] = 7;
    step(60);
    chk("R4 input0 requalified", int'(los_status[0]), 0);
    chk("R5 revertive to input0", int'(sel_idx), 0);
    need_good = 4'd0;
    per[1] = 8; cfg_write(1, 20, 2); step(40);
    chk("R4 need 0 acts as 1", int'(los_status[1]), 0);

    step(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule